// File: doc/BRIEF.md
# Pipeline Hazard Stall Accounting Unit

This block sits beside the issue stage of a small 32-bit in-order pipeline and works out how many bubble cycles each retiring instruction must be preceded by. Every cycle in which an instruction retires, the pipeline presents a compact description of it. That description holds an optional source register, an optional destination register, an optional run of registers written by a multi-register load, and flags for a memory read, a memory write, a taken jump, a jump through a register and a multiply. It also gives the immediate size and the low bits of the PC. The unit compares this against a three-deep history of which registers were recently modified. It reports the total stall count one cycle later.

Register indices 0 to 15 are general registers. Index 16+n names special register n, so the multiply high-result register (special 7) is index 23. Two indices belong to registers that always read as zero. Their history bits are reused as markers: bit 16 means "a jump was taken" and bit 20 means "memory was written". Every stall cycle that is inserted ages both histories by one slot, exactly as an empty instruction would. A saturating counter per hazard class accumulates the inserted cycles and can be read through a select port.

Top module: `hazard_stall_unit`

## Requirements
- R1: After synchronous reset, stall_valid and stall_total are 0, every class counter reads 0, and the history is empty, so no instruction stalls.
- R2: Load-use class (select 0): if the valid source register was a multi-register-load target 1, 2 or 3 instructions earlier, 3, 2 or 1 stalls are inserted; only the nearest match counts.
- R3: An instruction with k stalls shifts both histories k slots before its own entry is pushed; older entries are cleared, not kept.
- R4: Memory-hazard class (select 1): a memory read costs 2 stalls when either of the two previous history slots has the memory-write marker (bit 20).
- R5: Jump-source class (select 2): a jump through a valid register costs 2 stalls if the newest slot marks that register, otherwise 1 stall if the second slot marks it.
- R6: Multiply class (select 3): a multiply costs 1 stall when its valid source or valid destination is set in the newest slot; a multiply also marks index 23 as modified.
- R7: Jump-target class (select 4): when the newest slot has the jump marker (bit 16), a 16-bit immediate (imm_kind=1) with pc_low=4'hF, or a 32-bit immediate (imm_kind=2) with pc_low=4'hE, costs 1 stall; other combinations cost nothing.
- R8: Destination writes to index 16 or 20 set no marker bit; writes to other special indices are tracked.
- R9: A cleared valid flag on the source, destination or jump register removes that operand from every hazard check.
- R10: Each class counter adds its stalls per instruction and saturates at its all-ones value.
- R11: A cycle with ins_valid low changes no history and gives stall_valid low on the next cycle.
- R12: stall_total, presented one cycle after the instruction, equals the sum of all class stalls (at most 9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | An instruction retires this cycle |
| src_valid | input | 1 | Source operand present |
| src_reg | input | 5 | Source register index |
| dst_valid | input | 1 | Destination operand present |
| dst_reg | input | 5 | Destination register index |
| mload_valid | input | 1 | Instruction is a multi-register load |
| mload_last | input | 4 | Highest register loaded; registers 0..mload_last are written |
| mem_read | input | 1 | Instruction reads memory |
| mem_write | input | 1 | Instruction writes memory |
| jump_taken | input | 1 | Instruction takes a jump |
| jreg_valid | input | 1 | Instruction jumps through a register |
| jreg | input | 5 | Jump register index |
| is_mul | input | 1 | Instruction is a multiply |
| imm_kind | input | 2 | 0 none, 1 16-bit immediate, 2 32-bit immediate |
| pc_low | input | 4 | PC bits 4:1 of the instruction |
| cnt_sel | input | 3 | Class counter select (0..4; other values read 0) |
| stall_valid | output | 1 | stall_total belongs to the previous cycle's instruction |
| stall_total | output | 4 | Stall cycles for that instruction |
| cnt_value | output | CNT_W | Selected class counter |

## Verification
The bench builds the unit with CNT_W set to 4, so a class counter reaches its all-ones value after a handful of two-cycle jump hazards and the clamp becomes observable. The default 32-bit width would need billions of stalls. All other structure is fixed by the package, so each scenario covers the full three-slot history and every marker bit at the sizes used in the design.

// File: rtl/hsu_pkg.sv
package hsu_pkg;

    localparam int MASK_W    = 32;
    localparam int HIST_D    = 3;
    localparam int NCLS      = 5;
    localparam int AMT_W     = 2;
    localparam int TOT_W     = 4;
    localparam int SEL_W     = $clog2(NCLS);
    localparam int GPR_N     = 16;
    localparam int JUMP_BIT  = 16;
    localparam int MEMW_BIT  = 20;
    localparam int MULHI_BIT = 23;

    typedef logic [MASK_W-1:0] mask_t;
    typedef logic [HIST_D-1:0][MASK_W-1:0] hist_t;
    typedef logic [NCLS-1:0][AMT_W-1:0] amt_vec_t;

    typedef enum logic [SEL_W-1:0] {
        CLS_LOADUSE = 3'd0,
        CLS_MEMRAW  = 3'd1,
        CLS_JSRC    = 3'd2,
        CLS_MULSRC  = 3'd3,
        CLS_JTGT    = 3'd4
    } cls_e;

    typedef enum logic [1:0] {
        IMM_NONE = 2'd0,
        IMM_16   = 2'd1,
        IMM_32   = 2'd2
    } imm_e;

    typedef struct packed {
        logic       src_v;
        logic [4:0] src;
        logic       dst_v;
        logic [4:0] dst;
        logic       mld_v;
        logic [3:0] mld_last;
        logic       mrd;
        logic       mwr;
        logic       jmp;
        logic       jr_v;
        logic [4:0] jr;
        logic       mul;
        imm_e       imm;
        logic [3:0] pc41;
    } insn_t;

    function automatic mask_t one_bit(input logic [4:0] idx);
        mask_t m;
        m = '0;
        m[idx] = 1'b1;
        return m;
    endfunction

    function automatic mask_t low_run(input logic [3:0] last);
        mask_t m;
        m = '0;
        for (int i = 0; i < GPR_N; i++)
            if (i <= int'(last)) m[i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/hsu_history.sv
module hsu_history
    import hsu_pkg::*;
#(
    parameter int W = MASK_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   upd,
    input  logic [TOT_W-1:0]       shift,
    input  logic [W-1:0]           new_entry,
    output logic [HIST_D-1:0][W-1:0] slots
);

    logic [HIST_D-1:0][W-1:0] nxt;

    always_comb begin
        nxt[0] = new_entry;
        for (int i = 1; i < HIST_D; i++) begin
            nxt[i] = '0;
            for (int j = 0; j < HIST_D; j++)
                if (j + int'(shift) + 1 == i) nxt[i] = slots[j];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)      slots <= '0;
        else if (upd) slots <= nxt;
    end

    a_r3_aged_slot_cleared: assert property (@(posedge clk) disable iff (rst)
        (upd && shift != '0) |=> (slots[1] == '0));

    a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(slots));

endmodule

// File: rtl/hsu_detect.sv
module hsu_detect
    import hsu_pkg::*;
(
    input  insn_t             ins,
    input  hist_t             mod_h,
    input  hist_t             mld_h,
    output amt_vec_t          amt,
    output logic [TOT_W-1:0]  total,
    output mask_t             mod_new,
    output mask_t             mld_new
);

    mask_t src_m, dst_m, jr_m, run_m;
    logic  dst_zero;

    always_comb begin
        src_m    = ins.src_v ? one_bit(ins.src) : '0;
        dst_m    = ins.dst_v ? one_bit(ins.dst) : '0;
        jr_m     = ins.jr_v  ? one_bit(ins.jr)  : '0;
        run_m    = ins.mld_v ? low_run(ins.mld_last) : '0;
        dst_zero = (ins.dst == 5'(JUMP_BIT)) || (ins.dst == 5'(MEMW_BIT));
    end

    // per-class stall amounts, all read from the history at instruction start
    always_comb begin
        amt = '0;
        if ((mld_h[0] & src_m) != '0)      amt[CLS_LOADUSE] = 2'd3;
        else if ((mld_h[1] & src_m) != '0) amt[CLS_LOADUSE] = 2'd2;
        else if ((mld_h[2] & src_m) != '0) amt[CLS_LOADUSE] = 2'd1;

        if (ins.mrd && (mod_h[0][MEMW_BIT] || mod_h[1][MEMW_BIT]))
            amt[CLS_MEMRAW] = 2'd2;

        if ((mod_h[0] & jr_m) != '0)      amt[CLS_JSRC] = 2'd2;
        else if ((mod_h[1] & jr_m) != '0) amt[CLS_JSRC] = 2'd1;

        if (ins.mul && ((mod_h[0] & (src_m | dst_m)) != '0))
            amt[CLS_MULSRC] = 2'd1;

        if (mod_h[0][JUMP_BIT] &&
            ((ins.imm == IMM_16 && ins.pc41 == 4'hF) ||
             (ins.imm == IMM_32 && ins.pc41 == 4'hE)))
            amt[CLS_JTGT] = 2'd1;
    end

    always_comb begin
        total = '0;
        for (int c = 0; c < NCLS; c++)
            total = total + TOT_W'(amt[c]);
    end

    always_comb begin
        mod_new = run_m;
        if (ins.dst_v && !dst_zero) mod_new = mod_new | dst_m;
        mod_new[JUMP_BIT]  = ins.jmp;
        mod_new[MEMW_BIT]  = ins.mwr;
        mod_new[MULHI_BIT] = mod_new[MULHI_BIT] | ins.mul;
        mld_new = run_m;
    end

endmodule

// File: rtl/hsu_counters.sv
module hsu_counters
    import hsu_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  amt_vec_t         amt,
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] value
);

    logic [NCLS-1:0][CNT_W-1:0] cnt_q;

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        logic [CNT_W:0] sum;
        assign sum = {1'b0, cnt_q[c]} + (CNT_W+1)'(amt[c]);

        always_ff @(posedge clk) begin
            if (rst)     cnt_q[c] <= '0;
            else if (en) cnt_q[c] <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
        end

        a_r10_no_wrap: assert property (@(posedge clk) disable iff (rst)
            en |=> (cnt_q[c] >= $past(cnt_q[c])));
    end

    always_comb begin
        value = '0;
        for (int c = 0; c < NCLS; c++)
            if (sel == SEL_W'(c)) value = cnt_q[c];
    end

endmodule

// File: rtl/hazard_stall_unit.sv
module hazard_stall_unit
    import hsu_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ins_valid,
    input  logic             src_valid,
    input  logic [4:0]       src_reg,
    input  logic             dst_valid,
    input  logic [4:0]       dst_reg,
    input  logic             mload_valid,
    input  logic [3:0]       mload_last,
    input  logic             mem_read,
    input  logic             mem_write,
    input  logic             jump_taken,
    input  logic             jreg_valid,
    input  logic [4:0]       jreg,
    input  logic             is_mul,
    input  logic [1:0]       imm_kind,
    input  logic [3:0]       pc_low,
    input  logic [2:0]       cnt_sel,
    output logic             stall_valid,
    output logic [3:0]       stall_total,
    output logic [CNT_W-1:0] cnt_value
);

    insn_t            ins;
    hist_t            mod_h, mld_h;
    amt_vec_t         amt;
    logic [TOT_W-1:0] total_c;
    mask_t            mod_new, mld_new;

    always_comb begin
        ins.src_v    = src_valid;
        ins.src      = src_reg;
        ins.dst_v    = dst_valid;
        ins.dst      = dst_reg;
        ins.mld_v    = mload_valid;
        ins.mld_last = mload_last;
        ins.mrd      = mem_read;
        ins.mwr      = mem_write;
        ins.jmp      = jump_taken;
        ins.jr_v     = jreg_valid;
        ins.jr       = jreg;
        ins.mul      = is_mul;
        ins.imm      = imm_e'(imm_kind);
        ins.pc41     = pc_low;
    end

    hsu_detect u_detect (
        .ins     (ins),
        .mod_h   (mod_h),
        .mld_h   (mld_h),
        .amt     (amt),
        .total   (total_c),
        .mod_new (mod_new),
        .mld_new (mld_new)
    );

    hsu_history #(.W(MASK_W)) u_mod_hist (
        .clk       (clk),
        .rst       (rst),
        .upd       (ins_valid),
        .shift     (total_c),
        .new_entry (mod_new),
        .slots     (mod_h)
    );

    hsu_history #(.W(MASK_W)) u_mld_hist (
        .clk       (clk),
        .rst       (rst),
        .upd       (ins_valid),
        .shift     (total_c),
        .new_entry (mld_new),
        .slots     (mld_h)
    );

    hsu_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .en    (ins_valid),
        .amt   (amt),
        .sel   (cnt_sel),
        .value (cnt_value)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stall_valid <= 1'b0;
            stall_total <= '0;
        end else begin
            stall_valid <= ins_valid;
            stall_total <= ins_valid ? total_c : '0;
        end
    end

    a_r11_idle_no_report: assert property (@(posedge clk) disable iff (rst)
        !ins_valid |=> !stall_valid);

    a_r12_total_bounded: assert property (@(posedge clk) disable iff (rst)
        stall_valid |-> (stall_total <= 4'd9));

    a_r6_mul_marks_high: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && is_mul) |=> mod_h[0][MULHI_BIT]);

    a_r8_zero_dest_no_jump_mark: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !jump_taken) |=> !mod_h[0][JUMP_BIT]);

endmodule

// File: tb/test_hazard_stall_unit.sv
`timescale 1ns/1ps
module test_hazard_stall_unit;

    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          ins_valid, src_valid, dst_valid, mload_valid;
    logic [4:0]    src_reg, dst_reg, jreg;
    logic [3:0]    mload_last, pc_low;
    logic          mem_read, mem_write, jump_taken, jreg_valid, is_mul;
    logic [1:0]    imm_kind;
    logic [2:0]    cnt_sel;
    logic          stall_valid;
    logic [3:0]    stall_total;
    logic [CW-1:0] cnt_value;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    hazard_stall_unit #(.CNT_W(CW)) i_hazard_stall_unit (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr();
        ins_valid = 0; src_valid = 0; src_reg = 0; dst_valid = 0; dst_reg = 0;
        mload_valid = 0; mload_last = 0; mem_read = 0; mem_write = 0;
        jump_taken = 0; jreg_valid = 0; jreg = 0; is_mul = 0;
        imm_kind = 0; pc_low = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        clr();
    endtask

    task automatic do_reset();
        clr();
        cnt_sel = 0;
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    task automatic filler(input int n);
        for (int i = 0; i < n; i++) begin
            ins_valid = 1;
            tick();
        end
    endtask

    task automatic read_cnt(input string req, input int sel, input int exp);
        cnt_sel = 3'(sel);
        #1;
        chk(req, int'(cnt_value), exp);
    endtask

    task automatic mload03();
        ins_valid = 1; mload_valid = 1; mload_last = 3;
        tick();
    endtask

    task automatic use_src(input int r);
        ins_valid = 1; src_valid = 1; src_reg = 5'(r);
        tick();
    endtask

    task automatic wr_dst(input int r);
        ins_valid = 1; dst_valid = 1; dst_reg = 5'(r);
        tick();
    endtask

    task automatic jump_via(input int r);
        ins_valid = 1; jreg_valid = 1; jreg = 5'(r);
        tick();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 stall_valid", int'(stall_valid), 0);
        chk("R1 stall_total", int'(stall_total), 0);
        for (int s = 0; s < 5; s++) read_cnt("R1 counter", s, 0);
        use_src(1);
        chk("R1 empty history", int'(stall_total), 0);
    endtask

    task automatic t_loaduse();
        do_reset(); mload03(); use_src(2);
        chk("R2 distance 1", int'(stall_total), 3);
        do_reset(); mload03(); filler(1); use_src(1);
        chk("R2 distance 2", int'(stall_total), 2);
        do_reset(); mload03(); filler(2); use_src(1);
        chk("R2 distance 3", int'(stall_total), 1);
        do_reset(); mload03(); filler(3); use_src(1);
        chk("R2 distance 4", int'(stall_total), 0);
        do_reset();
        ins_valid = 1; mload_valid = 1; mload_last = 1; tick();
        mload03(); use_src(1);
        chk("R2 nearest only", int'(stall_total), 3);
        read_cnt("R2 counter", 0, 3);
    endtask

    task automatic t_aging();
        do_reset(); mload03(); use_src(1);
        chk("R3 first use", int'(stall_total), 3);
        use_src(2);
        chk("R3 aged out", int'(stall_total), 0);
        do_reset(); wr_dst(6);
        ins_valid = 1; mem_write = 1; tick();
        ins_valid = 1; mem_read = 1; tick();
        chk("R3 read stalls", int'(stall_total), 2);
        jump_via(6);
        chk("R3 dst aged by stalls", int'(stall_total), 0);
    endtask

    task automatic t_memraw();
        do_reset();
        ins_valid = 1; mem_write = 1; tick();
        ins_valid = 1; mem_read = 1; tick();
        chk("R4 write then read", int'(stall_total), 2);
        do_reset();
        ins_valid = 1; mem_write = 1; tick(); filler(1);
        ins_valid = 1; mem_read = 1; tick();
        chk("R4 gap one", int'(stall_total), 2);
        do_reset();
        ins_valid = 1; mem_write = 1; tick(); filler(2);
        ins_valid = 1; mem_read = 1; tick();
        chk("R4 gap two", int'(stall_total), 0);
        read_cnt("R4 counter", 1, 0);
    endtask

    task automatic t_jsrc();
        do_reset(); wr_dst(5); jump_via(5);
        chk("R5 adjacent", int'(stall_total), 2);
        do_reset(); wr_dst(5); filler(1); jump_via(5);
        chk("R5 one back", int'(stall_total), 1);
        read_cnt("R5 counter", 2, 1);
        do_reset(); wr_dst(5); filler(2); jump_via(5);
        chk("R5 two back", int'(stall_total), 0);
    endtask

    task automatic t_mul();
        do_reset(); wr_dst(3);
        ins_valid = 1; is_mul = 1; src_valid = 1; src_reg = 3;
        dst_valid = 1; dst_reg = 4; tick();
        chk("R6 mul source hazard", int'(stall_total), 1);
        jump_via(23);
        chk("R6 high result marked", int'(stall_total), 2);
        read_cnt("R6 counter", 3, 1);
        do_reset(); wr_dst(4);
        ins_valid = 1; is_mul = 1; src_valid = 1; src_reg = 1;
        dst_valid = 1; dst_reg = 4; tick();
        chk("R6 mul dest-input hazard", int'(stall_total), 1);
    endtask

    task automatic t_jtgt();
        do_reset();
        ins_valid = 1; jump_taken = 1; tick();
        ins_valid = 1; imm_kind = 1; pc_low = 4'hF; tick();
        chk("R7 imm16 straddle", int'(stall_total), 1);
        do_reset();
        ins_valid = 1; jump_taken = 1; tick();
        ins_valid = 1; imm_kind = 2; pc_low = 4'hE; tick();
        chk("R7 imm32 straddle", int'(stall_total), 1);
        read_cnt("R7 counter", 4, 1);
        do_reset();
        ins_valid = 1; jump_taken = 1; tick();
        ins_valid = 1; imm_kind = 1; pc_low = 4'hE; tick();
        chk("R7 imm16 no straddle", int'(stall_total), 0);
        do_reset();
        ins_valid = 1; imm_kind = 1; pc_low = 4'hF; tick();
        chk("R7 no jump", int'(stall_total), 0);
    endtask

    task automatic t_zero_regs();
        do_reset(); wr_dst(16);
        ins_valid = 1; imm_kind = 1; pc_low = 4'hF; tick();
        chk("R8 index16 no jump mark", int'(stall_total), 0);
        do_reset(); wr_dst(20);
        ins_valid = 1; mem_read = 1; tick();
        chk("R8 index20 no write mark", int'(stall_total), 0);
        do_reset(); wr_dst(17); jump_via(17);
        chk("R8 special tracked", int'(stall_total), 2);
    endtask

    task automatic t_invalid();
        do_reset(); mload03();
        ins_valid = 1; src_valid = 0; src_reg = 1; tick();
        chk("R9 src invalid", int'(stall_total), 0);
        do_reset();
        ins_valid = 1; dst_valid = 0; dst_reg = 5; tick();
        jump_via(5);
        chk("R9 dst invalid", int'(stall_total), 0);
        do_reset(); wr_dst(5);
        ins_valid = 1; jreg_valid = 0; jreg = 5; tick();
        chk("R9 jreg invalid", int'(stall_total), 0);
    endtask

    task automatic t_saturate();
        do_reset();
        for (int i = 0; i < 7; i++) begin
            wr_dst(5); jump_via(5);
        end
        read_cnt("R10 accumulate", 2, 14);
        wr_dst(5); jump_via(5);
        read_cnt("R10 clamp", 2, 15);
        wr_dst(5); jump_via(5);
        read_cnt("R10 stays", 2, 15);
    endtask

    task automatic t_idle();
        do_reset(); wr_dst(5);
        ins_valid = 0; tick();
        chk("R11 no report", int'(stall_valid), 0);
        jump_via(5);
        chk("R11 history held", int'(stall_total), 2);
        chk("R11 report back", int'(stall_valid), 1);
    endtask

    task automatic t_sum();
        do_reset(); wr_dst(0);
        ins_valid = 1; mload_valid = 1; mload_last = 3;
        mem_write = 1; jump_taken = 1; tick();
        ins_valid = 1; src_valid = 1; src_reg = 1; mem_read = 1;
        jreg_valid = 1; jreg = 0; is_mul = 1; imm_kind = 1; pc_low = 4'hF;
        tick();
        chk("R12 all classes", int'(stall_total), 9);
        read_cnt("R12 loaduse part", 0, 3);
        read_cnt("R12 jsrc part", 2, 2);
        read_cnt("R12 unused select", 7, 0);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        clr();
        cnt_sel = 0;
        rst = 1;
        @(negedge clk);
        t_reset();
        t_loaduse();
        t_aging();
        t_memraw();
        t_jsrc();
        t_mul();
        t_jtgt();
        t_zero_regs();
        t_invalid();
        t_saturate();
        t_idle();
        t_sum();
        report();
    end

endmodule